// File: doc/BRIEF.md
# I2C tuning register receiver

This block is a write-only I2C target that feeds the tuning core of a frequency synthesiser. A host sends telegrams over SCL and SDA. The block picks out its own address and acknowledges it, then sorts each data byte into either the 15-bit divider ratio or the control and port bits. The result is held on plain level outputs that the synthesiser core reads directly.

Two address bits come from a hard-wired select input, so four copies can share one bus. Each pair of data bytes is self-describing: the leading bit of the first byte of a pair chooses its kind. The divider pair and the control pair may arrive in either order, and a stop may end the telegram after any byte.

The bus cannot be held off, because this block has no clock stretching. For that reason there is no valid/ready path: every register output changes only at the end of an acknowledge pulse and stays put in between. The raw SCL and SDA pins are oversampled by the system clock, synchronised and glitch-filtered before any edge is detected.

Top module: `tune_i2c_rx`

## Requirements
- R1: While reset is active and right after it, `sda_pull_o` is 0, `div_ratio_o` is 0, and every control and port bit is 0.
- R2: A telegram opens on SDA falling while SCL is high, and closes on SDA rising while SCL is high. Bits are sampled on SCL rising, MSB first. The first byte is matched against 1,1,0,0,0, then `addr_sel_i[1]`, `addr_sel_i[0]`, then a write bit of 0.
- R3: On an address match, and after every data byte that follows it, `sda_pull_o` is 1 from the falling SCL edge that ends the eighth bit to the falling SCL edge that ends the ninth pulse. `sda_pull_o` only changes while SCL is low.
- R4: If the address does not match, or its last bit is 1 (read), there is no acknowledge. Every byte up to the next start condition is then ignored, and no output changes.
- R5: A first-of-pair byte whose bit 7 is 0 is divider byte 1: its bits 6..0 load `div_ratio_o[14:8]`. The byte that follows loads `div_ratio_o[7:0]`.
- R6: A first-of-pair byte whose bit 7 is 1 is control byte 1. Its bit 6 drives `pump_hi_o`, bit 5 drives `test_ref_o`, bit 4 drives `pump_hiz_o` and bit 0 drives `drv_off_o`. The byte that follows sets `band_o` = {bit7, bit4, bit2, bit1, bit0}, which means `band_o[4]` is the P7 output and `band_o[0]` is P0.
- R7: The byte after a completed pair is classified afresh by its bit 7. Divider-then-control and control-then-divider orders both work.
- R8: A stop after any byte keeps every field already written. A pair cut after its first byte changes only that first byte's field.
- R9: A repeated start begins a new address phase and discards any half-finished pair. The first data byte after it is always treated as a first-of-pair byte.
- R10: Each register field changes only on the falling SCL edge that ends the acknowledge of its byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to oversample the bus |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Raw bus clock line |
| sda_i | input | 1 | Raw bus data line, as seen on the wire |
| addr_sel_i | input | 2 | Hard-wired address select bits |
| sda_pull_o | output | 1 | 1 pulls SDA low (open-drain acknowledge) |
| div_ratio_o | output | 15 | Programmable divider ratio |
| pump_hi_o | output | 1 | High charge-pump current select |
| test_ref_o | output | 1 | Test routing select |
| pump_hiz_o | output | 1 | Charge pump forced to high impedance |
| drv_off_o | output | 1 | Tuning driver disable |
| band_o | output | 5 | Band and port outputs {P7, P4, P2, P1, P0} |

## Verification
The bench sends a repeated start after a lone control byte 1. If the design kept its pairing state, it would take the following divider byte as control byte 2 and corrupt `band_o`. Telegrams that stop after one byte of a pair show whether a design loads a half-received field or wipes the other half. A wrong address, and a correct address with the read bit set, are followed by data bytes: a design that does not stay silent until the next start would acknowledge them or load them. A divider byte sent as the third byte after a full pair checks that classification resets per pair rather than per telegram.

// File: rtl/tune_i2c_pkg.sv
package tune_i2c_pkg;
  typedef enum logic [2:0] {
    EN_IDLE,
    EN_ADDR,
    EN_DATA,
    EN_ACK,
    EN_SKIP
  } eng_state_t;

  typedef struct packed {
    logic pump_hi;
    logic ref_test;
    logic pump_hiz;
    logic drv_off;
  } ctrl_t;
endpackage

// File: rtl/i2c_line_filter.sv
module i2c_line_filter #(
  parameter int FILT_LEN = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic raw_i,
  output logic clean_o
);
  localparam int CW = $clog2(FILT_LEN) + 1;

  logic          s1, s2;
  logic [CW-1:0] cnt;

  // Two-flop synchroniser, then the output follows only a level held FILT_LEN cycles
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1      <= 1'b1;
      s2      <= 1'b1;
      clean_o <= 1'b1;
      cnt     <= '0;
    end else begin
      s1 <= raw_i;
      s2 <= s1;
      if (s2 == clean_o) begin
        cnt <= '0;
      end else if (cnt == CW'(FILT_LEN - 1)) begin
        clean_o <= s2;
        cnt     <= '0;
      end else begin
        cnt <= cnt + 1'b1;
      end
    end
  end
endmodule

// File: rtl/i2c_bus_events.sv
module i2c_bus_events (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_f,
  input  logic sda_f,
  output logic start_o,
  output logic stop_o,
  output logic scl_rise_o,
  output logic scl_fall_o
);
  logic scl_q, sda_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_q <= scl_f;
      sda_q <= sda_f;
    end
  end

  assign start_o    = scl_f & scl_q & sda_q & ~sda_f;
  assign stop_o     = scl_f & scl_q & ~sda_q & sda_f;
  assign scl_rise_o = scl_f & ~scl_q;
  assign scl_fall_o = ~scl_f & scl_q;
endmodule

// File: rtl/i2c_byte_engine.sv
module i2c_byte_engine
  import tune_i2c_pkg::*;
#(
  parameter int BYTE_W = 8,
  parameter int SEL_W  = 2,
  parameter logic [BYTE_W-SEL_W-2:0] ADDR_PREFIX = 5'b11000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic              stop_i,
  input  logic              scl_rise_i,
  input  logic              scl_fall_i,
  input  logic              sda_f,
  input  logic [SEL_W-1:0]  addr_sel_i,
  output logic              sda_pull_o,
  output logic              commit_o,
  output logic [BYTE_W-1:0] byte_o,
  output logic              skip_o
);
  localparam int CNT_W = $clog2(BYTE_W + 1);
  localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(BYTE_W);

  eng_state_t        state;
  logic [CNT_W-1:0]  cnt;
  logic [BYTE_W-1:0] shreg;
  logic              ack_data;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state      <= EN_IDLE;
      cnt        <= '0;
      shreg      <= '0;
      sda_pull_o <= 1'b0;
      commit_o   <= 1'b0;
      ack_data   <= 1'b0;
    end else begin
      commit_o <= 1'b0;
      if (start_i) begin
        state      <= EN_ADDR;
        cnt        <= '0;
        sda_pull_o <= 1'b0;
      end else if (stop_i) begin
        state      <= EN_IDLE;
        sda_pull_o <= 1'b0;
      end else begin
        case (state)
          EN_ADDR, EN_DATA: begin
            if (scl_rise_i && cnt != CNT_FULL) begin
              shreg <= {shreg[BYTE_W-2:0], sda_f};
              cnt   <= cnt + 1'b1;
            end else if (scl_fall_i && cnt == CNT_FULL) begin
              if (state == EN_DATA) begin
                sda_pull_o <= 1'b1;
                ack_data   <= 1'b1;
                state      <= EN_ACK;
              end else if (shreg == {ADDR_PREFIX, addr_sel_i, 1'b0}) begin
                sda_pull_o <= 1'b1;
                ack_data   <= 1'b0;
                state      <= EN_ACK;
              end else begin
                state <= EN_SKIP;
              end
            end
          end
          EN_ACK: begin
            if (scl_fall_i) begin
              sda_pull_o <= 1'b0;
              cnt        <= '0;
              state      <= EN_DATA;
              commit_o   <= ack_data;
            end
          end
          default: ;
        endcase
      end
    end
  end

  assign byte_o = shreg;
  assign skip_o = (state == EN_SKIP);
endmodule

// File: rtl/tune_reg_file.sv
module tune_reg_file
  import tune_i2c_pkg::*;
#(
  parameter int DIV_W = 15
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic             commit_i,
  input  logic [7:0]       byte_i,
  output logic [DIV_W-1:0] div_o,
  output ctrl_t            ctrl_o,
  output logic [4:0]       band_o
);
  localparam int HI_W = DIV_W - 8;

  logic second;   // next committed byte completes a pair
  logic kind;     // 1: pair in progress is control, 0: divider

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      second <= 1'b0;
      kind   <= 1'b0;
      div_o  <= '0;
      ctrl_o <= '0;
      band_o <= '0;
    end else if (start_i) begin
      second <= 1'b0;
    end else if (commit_i) begin
      if (!second) begin
        second <= 1'b1;
        kind   <= byte_i[7];
        if (byte_i[7]) begin
          ctrl_o <= '{pump_hi: byte_i[6], ref_test: byte_i[5],
                      pump_hiz: byte_i[4], drv_off: byte_i[0]};
        end else begin
          div_o[DIV_W-1:8] <= byte_i[HI_W-1:0];
        end
      end else begin
        second <= 1'b0;
        if (kind) begin
          band_o <= {byte_i[7], byte_i[4], byte_i[2], byte_i[1], byte_i[0]};
        end else begin
          div_o[7:0] <= byte_i;
        end
      end
    end
  end
endmodule

// File: rtl/tune_i2c_rx.sv
module tune_i2c_rx
  import tune_i2c_pkg::*;
#(
  parameter int FILT_LEN = 3,
  parameter int DIV_W    = 15,
  parameter int SEL_W    = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             scl_i,
  input  logic             sda_i,
  input  logic [SEL_W-1:0] addr_sel_i,
  output logic             sda_pull_o,
  output logic [DIV_W-1:0] div_ratio_o,
  output logic             pump_hi_o,
  output logic             test_ref_o,
  output logic             pump_hiz_o,
  output logic             drv_off_o,
  output logic [4:0]       band_o
);
  logic [1:0] raw, clean;
  logic       scl_f, sda_f;
  logic       start, stop, scl_rise, scl_fall;
  logic       commit, skip;
  logic [7:0] rx_byte;
  ctrl_t      ctrl;

  assign raw = {scl_i, sda_i};

  for (genvar g = 0; g < 2; g++) begin : g_line
    i2c_line_filter #(.FILT_LEN(FILT_LEN)) u_filt (
      .clk(clk), .rst_n(rst_n), .raw_i(raw[g]), .clean_o(clean[g])
    );
  end

  assign scl_f = clean[1];
  assign sda_f = clean[0];

  i2c_bus_events u_evt (
    .clk(clk), .rst_n(rst_n), .scl_f(scl_f), .sda_f(sda_f),
    .start_o(start), .stop_o(stop), .scl_rise_o(scl_rise), .scl_fall_o(scl_fall)
  );

  i2c_byte_engine #(.BYTE_W(8), .SEL_W(SEL_W)) u_eng (
    .clk(clk), .rst_n(rst_n), .start_i(start), .stop_i(stop),
    .scl_rise_i(scl_rise), .scl_fall_i(scl_fall), .sda_f(sda_f),
    .addr_sel_i(addr_sel_i), .sda_pull_o(sda_pull_o), .commit_o(commit),
    .byte_o(rx_byte), .skip_o(skip)
  );

  tune_reg_file #(.DIV_W(DIV_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .start_i(start), .commit_i(commit),
    .byte_i(rx_byte), .div_o(div_ratio_o), .ctrl_o(ctrl), .band_o(band_o)
  );

  assign pump_hi_o  = ctrl.pump_hi;
  assign test_ref_o = ctrl.ref_test;
  assign pump_hiz_o = ctrl.pump_hiz;
  assign drv_off_o  = ctrl.drv_off;
endmodule

// File: rtl/tune_i2c_rx_chk.sv
module tune_i2c_rx_chk #(
  parameter int DIV_W = 15
) (
  input logic             clk,
  input logic             rst_n,
  input logic             scl_f,
  input logic             skip,
  input logic             commit,
  input logic             sda_pull_o,
  input logic [DIV_W-1:0] div_ratio_o,
  input logic [3:0]       ctrl_bits,
  input logic [4:0]       band_o
);
  // R1: never blocks the bus while in reset
  always @(posedge clk) begin
    if (!rst_n) begin
      a_r1_released_in_reset: assert (!sda_pull_o);
    end
  end

  // R3: the acknowledge drive only moves while SCL is low
  a_r3_pull_moves_scl_low: assert property (@(posedge clk) disable iff (!rst_n)
    (sda_pull_o != $past(sda_pull_o)) |-> !$past(scl_f));

  // R4: an ignored telegram is never acknowledged
  a_r4_skip_silent: assert property (@(posedge clk) disable iff (!rst_n)
    skip |-> !sda_pull_o);

  // R10: fields hold unless a byte has just finished its acknowledge
  a_r10_div_holds: assert property (@(posedge clk) disable iff (!rst_n)
    !commit |=> $stable(div_ratio_o));

  a_r10_ctrl_holds: assert property (@(posedge clk) disable iff (!rst_n)
    !commit |=> $stable(ctrl_bits));

  a_r10_band_holds: assert property (@(posedge clk) disable iff (!rst_n)
    !commit |=> $stable(band_o));
endmodule

bind tune_i2c_rx tune_i2c_rx_chk #(.DIV_W(DIV_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .scl_f(scl_f), .skip(skip), .commit(commit),
  .sda_pull_o(sda_pull_o), .div_ratio_o(div_ratio_o),
  .ctrl_bits({pump_hi_o, test_ref_o, pump_hiz_o, drv_off_o}), .band_o(band_o)
);

// File: tb/tune_i2c_rx_bench.sv
module tune_i2c_rx_bench;
  localparam int Q = 20;  // clock cycles per quarter bit

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        scl = 1'b1;
  logic        sda_drv = 1'b1;
  logic [1:0]  addr_sel = 2'b10;
  logic        sda_pull;
  logic        sda_line;
  logic [14:0] div_ratio;
  logic        pump_hi, test_ref, pump_hiz, drv_off;
  logic [4:0]  band;
  int          vectors = 0;
  int          miscompares = 0;
  bit          done = 1'b0;

  always #10 clk = ~clk;

  assign sda_line = sda_drv & ~sda_pull;

  tune_i2c_rx u_tune_i2c_rx (
    .clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(sda_line),
    .addr_sel_i(addr_sel), .sda_pull_o(sda_pull), .div_ratio_o(div_ratio),
    .pump_hi_o(pump_hi), .test_ref_o(test_ref), .pump_hiz_o(pump_hiz),
    .drv_off_o(drv_off), .band_o(band)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wq(input int n);
    repeat (n * Q) @(negedge clk);
  endtask

  task automatic bus_start();
    sda_drv = 1'b1; wq(1);
    scl = 1'b1;     wq(2);
    sda_drv = 1'b0; wq(2);
    scl = 1'b0;     wq(1);
  endtask

  task automatic bus_stop();
    scl = 1'b0; sda_drv = 1'b0; wq(1);
    scl = 1'b1; wq(2);
    sda_drv = 1'b1; wq(2);
  endtask

  task automatic send_byte(input logic [7:0] b, output logic acked);
    for (int i = 7; i >= 0; i--) begin
      scl = 1'b0; wq(1);
      sda_drv = b[i]; wq(1);
      scl = 1'b1; wq(2);
    end
    scl = 1'b0; wq(1);
    sda_drv = 1'b1; wq(1);
    scl = 1'b1; wq(1);
    acked = ~sda_line;
    wq(1);
    scl = 1'b0; wq(1);
  endtask

  function automatic logic [31:0] ctrl_now();
    return {28'd0, pump_hi, test_ref, pump_hiz, drv_off};
  endfunction

  task automatic t_reset();
    chk("R1 sda_pull", sda_pull, 0);
    chk("R1 div", div_ratio, 0);
    chk("R1 ctrl", ctrl_now(), 0);
    chk("R1 band", band, 0);
  endtask

  task automatic t_div_then_ctrl();
    logic a;
    bus_start();
    send_byte(8'hC4, a); chk("R2 addr ack", a, 1);
    send_byte(8'h2D, a); chk("R3 dr1 ack", a, 1);
    send_byte(8'h80, a); chk("R3 dr2 ack", a, 1);
    send_byte(8'hCB, a); chk("R3 cw1 ack", a, 1);
    send_byte(8'h95, a); chk("R3 cw2 ack", a, 1);
    chk("R3 released after ack", sda_pull, 0);
    bus_stop();
    chk("R5 div", div_ratio, 15'h2D80);
    chk("R6 ctrl", ctrl_now(), 4'b1001);
    chk("R6 band", band, 5'b11101);
  endtask

  task automatic t_ctrl_then_div();
    logic a;
    bus_start();
    send_byte(8'hC4, a); chk("R7 addr ack", a, 1);
    send_byte(8'hB6, a);
    send_byte(8'h4A, a);
    send_byte(8'h01, a);
    send_byte(8'h00, a); chk("R7 last ack", a, 1);
    bus_stop();
    chk("R7 ctrl", ctrl_now(), 4'b0110);
    chk("R7 band", band, 5'b00010);
    chk("R7 div", div_ratio, 15'h0100);
  endtask

  task automatic t_wrong_addr();
    logic a;
    bus_start();
    send_byte(8'hC2, a); chk("R4 foreign addr nack", a, 0);
    send_byte(8'h7F, a); chk("R4 data after nack", a, 0);
    send_byte(8'hFF, a);
    bus_stop();
    chk("R4 div unchanged", div_ratio, 15'h0100);
    bus_start();
    send_byte(8'hC5, a); chk("R4 read bit nack", a, 0);
    send_byte(8'hCB, a);
    send_byte(8'hFF, a);
    bus_stop();
    chk("R4 ctrl unchanged", ctrl_now(), 4'b0110);
    chk("R4 band unchanged", band, 5'b00010);
  endtask

  task automatic t_cut_short();
    logic a;
    bus_start();
    send_byte(8'hC4, a);
    send_byte(8'h12, a);
    bus_stop();
    chk("R8 div hi only", div_ratio, 15'h1200);
    bus_start();
    send_byte(8'hC4, a);
    send_byte(8'h80, a);
    bus_stop();
    chk("R8 ctrl cleared", ctrl_now(), 0);
    chk("R8 band kept", band, 5'b00010);
  endtask

  task automatic t_repeated_start();
    logic a;
    bus_start();
    send_byte(8'hC4, a);
    send_byte(8'hC1, a);
    bus_start();
    send_byte(8'hC4, a); chk("R9 addr ack after Sr", a, 1);
    send_byte(8'h55, a);
    send_byte(8'hAA, a);
    bus_stop();
    chk("R9 div", div_ratio, 15'h55AA);
    chk("R9 band untouched", band, 5'b00010);
    chk("R9 ctrl from first part", ctrl_now(), 4'b1001);
  endtask

  task automatic t_third_byte();
    logic a;
    bus_start();
    send_byte(8'hC4, a);
    send_byte(8'h03, a);
    send_byte(8'h21, a);
    send_byte(8'h04, a); chk("R7 third byte ack", a, 1);
    chk("R10 hi loaded at ack end", div_ratio, 15'h0421);
    bus_stop();
    chk("R7 third byte reclassified", div_ratio, 15'h0421);
  endtask

  task automatic t_other_select();
    logic a;
    addr_sel = 2'b01;
    bus_start();
    send_byte(8'hC2, a); chk("R2 select 01 ack", a, 1);
    send_byte(8'h00, a);
    send_byte(8'hFF, a);
    bus_stop();
    chk("R2 select 01 div", div_ratio, 15'h00FF);
  endtask

  initial begin
    repeat (5) @(negedge clk);
    chk("R1 pull in reset", sda_pull, 0);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    t_reset();
    t_div_then_ctrl();
    t_ctrl_then_div();
    t_wrong_addr();
    t_cut_short();
    t_repeated_start();
    t_third_byte();
    t_other_select();
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    repeat (190000) @(negedge clk);
    if (!done) begin
      vectors++;
      miscompares++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end
endmodule